// File: doc/BRIEF.md
# Paced Scan Channel Sequencer

The sequencer walks a stored scan list once for every pacer tick. Each list word names a channel type, a channel number and a range code. Analog entries become conversion requests, issued one at a time on a fixed channel-to-channel slot of `MIN_TICKS` clock cycles. Counter and digital-input entries take no slot. Instead, the whole digital group is captured by a single snapshot strobe at the start of each pacer interval.

The pacer tick comes from one of two sources. The internal source is an interval timer counting clock cycles. The external source is a pacer pin, which is synchronized and edge-detected. External edges that come too close together are flagged and dropped. A tick that lands while a scan is still running is also dropped and recorded as an overrun.

Before scanning starts, the block reads the whole active list once to validate it. If any analog entry uses the exclusive widest range while another analog entry uses a different range, the block refuses to run.

Top module: `pacer_scan_seq`

## Requirements
- R1: After reset, `conv_req`, `dig_snap`, `busy`, `armed`, `cfg_err`, `overrun` and `ext_fast` are all low.
- R2: Raising `en` starts a validation pass over the active entries, two cycles per entry. If the list is legal, `armed` then goes high and `cfg_err` stays low.
- R3: Each entry word is laid out as type in the top two bits, then a `CHW`-bit channel number, then an `RW`-bit range code in the low bits. Types are 00 differential analog, 01 single-ended analog, 10 counter and 11 digital input. If an analog entry carries `WIDE_CODE` and another analog entry carries any other range, `cfg_err` goes high, `armed` stays low and no request or snapshot is issued until `en` falls. Range codes of counter and digital entries are ignored by this check.
- R4: With the internal source selected, pacer ticks, and therefore scan starts, occur every max(`interval`, `MIN_TICKS`) cycles.
- R5: `clamped` is high whenever `interval` is below `MIN_TICKS`.
- R6: Each analog entry of the active list gives exactly one single-cycle `conv_req` per scan, in list order. It carries that entry's channel on `conv_chan` and its range on `conv_range`, and `conv_diff` is high for type 00.
- R7: Consecutive `conv_req` pulses within one scan are exactly `MIN_TICKS` cycles apart, provided no run of digital entries between two analog entries is longer than `MIN_TICKS`/2 − 1.
- R8: `dig_snap` pulses for one cycle at each accepted tick, only when the list holds a type 10 or 11 entry. It comes two cycles before the first `conv_req` when entry 0 is analog.
- R9: A tick arriving while `busy` is high sets `overrun` and is dropped, so the running scan finishes unchanged. `overrun` stays set until the next start.
- R10: With `ext_sel` high, scans start on rising edges of `ext_pacer`, and the internal timer has no effect.
- R11: An `ext_pacer` rising edge fewer than `MIN_TICKS` cycles after the previous one sets `ext_fast` and starts no scan.
- R12: Only entries 0 to `list_len`−1 are used. A value of 0 acts as 1, and values above `DEPTH` act as `DEPTH`.
- R13: Lowering `en` returns the block to idle, with `armed` and `busy` low. The next rise of `en` clears `overrun` and `ext_fast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; a rising level starts validation |
| wr_en | input | 1 | Scan list write strobe |
| wr_addr | input | AW | Scan list write index |
| wr_data | input | EW | Scan list entry word |
| list_len | input | AW+1 | Number of active entries |
| ext_sel | input | 1 | 1 selects the external pacer |
| interval | input | TICKW | Internal pacer interval in clock cycles |
| ext_pacer | input | 1 | External pacer pin (asynchronous) |
| conv_req | output | 1 | One-cycle analog conversion request |
| conv_diff | output | 1 | Request is differential |
| conv_chan | output | CHW | Channel of the request |
| conv_range | output | RW | Range code of the request |
| dig_snap | output | 1 | Digital group snapshot strobe |
| busy | output | 1 | A scan is in progress |
| armed | output | 1 | List validated, waiting for or running scans |
| cfg_err | output | 1 | List rejected by validation |
| overrun | output | 1 | Sticky: tick dropped during a scan |
| ext_fast | output | 1 | Sticky: external edge came too early |
| clamped | output | 1 | Programmed interval is below the minimum |

## Verification
The bench builds the block with `DEPTH`=16, `MIN_TICKS`=20, `CHW`=4, `RW`=3 and a 16-bit timer. With these values a slot is only 20 cycles, so several full scans, clamping, dropped ticks and too-close external edges all fit in a few hundred cycles each. Exact cycle spacings between requests, snapshots and scan starts can therefore be measured directly. The short list also allows every type to be mixed with the range-conflict cases, and it exercises the limit on list length.

// File: rtl/pacer_scan_seq.sv
module pacer_scan_seq #(
  parameter int DEPTH = 512,
  parameter int CHW = 6,
  parameter int RW = 3,
  parameter int TICKW = 32,
  parameter int MIN_TICKS = 250,
  parameter logic [RW-1:0] WIDE_CODE = '1,
  localparam int AW = $clog2(DEPTH),
  localparam int EW = 2 + CHW + RW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [EW-1:0]    wr_data,
  input  logic [AW:0]      list_len,
  input  logic             ext_sel,
  input  logic [TICKW-1:0] interval,
  input  logic             ext_pacer,
  output logic             conv_req,
  output logic             conv_diff,
  output logic [CHW-1:0]   conv_chan,
  output logic [RW-1:0]    conv_range,
  output logic             dig_snap,
  output logic             busy,
  output logic             armed,
  output logic             cfg_err,
  output logic             overrun,
  output logic             ext_fast,
  output logic             clamped
);
  localparam logic [AW:0]      DEPTH_V = (AW+1)'(DEPTH);
  localparam logic [TICKW-1:0] MIN_V   = TICKW'(MIN_TICKS);
  localparam logic [TICKW-1:0] SLOT_END = TICKW'(MIN_TICKS - 1);

  typedef enum logic [2:0] {IDLE, CHECK, WAIT, SCAN, ERR} st_t;
  st_t st;

  logic [EW-1:0]    mem [DEPTH];
  logic [EW-1:0]    rdata;
  logic [AW-1:0]    ptr;
  logic             rv;
  logic [TICKW-1:0] tmr, slot, gap;
  logic             s1, s2, s3;
  logic             saw_wide, saw_other, has_dig;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rdata <= mem[ptr];
  end

  wire [1:0]     e_type   = rdata[EW-1 -: 2];
  wire           e_analog = ~e_type[1];
  wire [CHW-1:0] e_chan   = rdata[RW +: CHW];
  wire [RW-1:0]  e_rng    = rdata[RW-1:0];

  wire [AW:0]   len_c    = (list_len == '0) ? (AW+1)'(1) :
                           (list_len > DEPTH_V) ? DEPTH_V : list_len;
  wire [AW-1:0] last_idx = AW'(len_c - 1);
  wire          at_last  = (ptr == last_idx);

  wire wide_n   = saw_wide  | (e_analog & (e_rng == WIDE_CODE));
  wire other_n  = saw_other | (e_analog & (e_rng != WIDE_CODE));

  assign clamped = interval < MIN_V;
  wire [TICKW-1:0] eff_int = clamped ? MIN_V : interval;

  wire running   = (st == WAIT) || (st == SCAN);
  wire ext_edge  = s2 & ~s3;
  wire fast_edge = ext_edge && (gap < MIN_V);
  wire tick      = running && (ext_sel ? (ext_edge && !fast_edge)
                                       : (tmr >= eff_int - 1'b1));

  assign busy    = (st == SCAN);
  assign armed   = running;
  assign cfg_err = (st == ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s1, s2, s3} <= '0;
      gap <= MIN_V;
    end else begin
      s1 <= ext_pacer;
      s2 <= s1;
      s3 <= s2;
      if (ext_edge) gap <= TICKW'(1);
      else if (gap < MIN_V) gap <= gap + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      ptr <= '0;
      rv <= 1'b0;
      tmr <= '0;
      slot <= '0;
      saw_wide <= 1'b0;
      saw_other <= 1'b0;
      has_dig <= 1'b0;
      conv_req <= 1'b0;
      conv_diff <= 1'b0;
      conv_chan <= '0;
      conv_range <= '0;
      dig_snap <= 1'b0;
      overrun <= 1'b0;
      ext_fast <= 1'b0;
    end else begin
      conv_req <= 1'b0;
      dig_snap <= 1'b0;
      if (running && ext_sel && fast_edge) ext_fast <= 1'b1;
      if (tick || !running) tmr <= '0;
      else tmr <= tmr + 1'b1;
      if (slot < SLOT_END) slot <= slot + 1'b1;

      if (!en) st <= IDLE;
      else begin
        case (st)
          IDLE: begin
            st <= CHECK;
            ptr <= '0;
            rv <= 1'b0;
            saw_wide <= 1'b0;
            saw_other <= 1'b0;
            has_dig <= 1'b0;
            overrun <= 1'b0;
            ext_fast <= 1'b0;
          end
          CHECK: begin
            if (!rv) rv <= 1'b1;
            else begin
              rv <= 1'b0;
              saw_wide <= wide_n;
              saw_other <= other_n;
              if (!e_analog) has_dig <= 1'b1;
              if (at_last) st <= (wide_n && other_n) ? ERR : WAIT;
              else ptr <= ptr + 1'b1;
            end
          end
          WAIT: begin
            if (tick) begin
              st <= SCAN;
              ptr <= '0;
              rv <= 1'b0;
              slot <= SLOT_END;
              dig_snap <= has_dig;
            end
          end
          SCAN: begin
            if (tick) overrun <= 1'b1;
            if (!rv) rv <= 1'b1;
            else if (!e_analog || slot == SLOT_END) begin
              if (e_analog) begin
                conv_req <= 1'b1;
                conv_diff <= (e_type == 2'b00);
                conv_chan <= e_chan;
                conv_range <= e_rng;
                slot <= '0;
              end
              rv <= 1'b0;
              if (at_last) st <= WAIT;
              else ptr <= ptr + 1'b1;
            end
          end
          default: st <= ERR;
        endcase
      end
    end
  end
endmodule

// File: rtl/pacer_scan_seq_chk.sv
module pacer_scan_seq_chk #(
  parameter int S = 250
) (
  input logic clk,
  input logic rst_n,
  input logic conv_req,
  input logic dig_snap,
  input logic busy,
  input logic armed,
  input logic cfg_err,
  input logic overrun
);
  int  since;
  logic in_scan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= 0;
      in_scan <= 1'b0;
    end else begin
      if (conv_req) since <= 1;
      else if (since < S + 1) since <= since + 1;
      if (conv_req) in_scan <= 1'b1;
      else if (!busy) in_scan <= 1'b0;
    end
  end

  a_r3_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!conv_req && !dig_snap && !armed));
  a_r2_armed_clean: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> !cfg_err);
  a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);
  a_r8_snap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dig_snap |=> !dig_snap);
  a_r8_snap_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    dig_snap |-> (busy && !conv_req));
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && busy) |=> overrun);
  a_r7_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && in_scan) |-> (since >= S));
endmodule

bind pacer_scan_seq pacer_scan_seq_chk #(.S(MIN_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .dig_snap(dig_snap),
  .busy(busy), .armed(armed), .cfg_err(cfg_err), .overrun(overrun)
);

// File: tb/pacer_scan_seq_tb.sv
module pacer_scan_seq_tb;
  localparam int DEPTH = 16, CHW = 4, RW = 3, TICKW = 16, S = 20;
  localparam int AW = 4, EW = 2 + CHW + RW;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, wr_en = 1'b0;
  logic ext_sel = 1'b0, ext_pacer = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [EW-1:0] wr_data = '0;
  logic [AW:0] list_len = 1;
  logic [TICKW-1:0] interval = 100;
  logic conv_req, conv_diff, dig_snap, busy, armed, cfg_err, overrun, ext_fast, clamped;
  logic [CHW-1:0] conv_chan;
  logic [RW-1:0] conv_range;

  pacer_scan_seq #(.DEPTH(DEPTH), .CHW(CHW), .RW(RW), .TICKW(TICKW), .MIN_TICKS(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .list_len(list_len), .ext_sel(ext_sel), .interval(interval), .ext_pacer(ext_pacer),
    .conv_req(conv_req), .conv_diff(conv_diff), .conv_chan(conv_chan), .conv_range(conv_range),
    .dig_snap(dig_snap), .busy(busy), .armed(armed), .cfg_err(cfg_err), .overrun(overrun),
    .ext_fast(ext_fast), .clamped(clamped));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nconv = 0, nsnap = 0, total = 0, fails = 0;
  int ct[64], stt[64], cc[64], cr[64], cd[64];
  bit done = 0;

  always @(negedge clk) if (rst_n) begin
    if (conv_req) begin
      if (nconv < 64) begin
        ct[nconv] = cyc; cc[nconv] = conv_chan; cr[nconv] = conv_range; cd[nconv] = conv_diff;
      end
      nconv++;
    end
    if (dig_snap) begin
      if (nsnap < 64) stt[nsnap] = cyc;
      nsnap++;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [EW-1:0] mk(int t, int ch, int rg);
    return {2'(t), CHW'(ch), RW'(rg)};
  endfunction

  task automatic wr(int a, logic [EW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr();
    nconv = 0; nsnap = 0;
  endtask

  task automatic pulse();
    ext_pacer = 1'b1; idle(3); ext_pacer = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 conv_req", conv_req, 0);
    chk("R1 dig_snap", dig_snap, 0);
    chk("R1 busy", busy, 0);
    chk("R1 armed", armed, 0);
    chk("R1 cfg_err", cfg_err, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 ext_fast", ext_fast, 0);
  endtask

  task automatic t_mixed();
    int ech[3] = '{3, 5, 9};
    int erg[3] = '{2, 4, 1};
    int edf[3] = '{1, 0, 1};
    wr(0, mk(0, 3, 2)); wr(1, mk(2, 1, 6)); wr(2, mk(1, 5, 4));
    wr(3, mk(3, 0, 0)); wr(4, mk(0, 9, 1));
    list_len = 5; interval = 100; ext_sel = 0;
    clr(); en = 1'b1;
    idle(12);
    chk("R2 armed", armed, 1);
    chk("R2 cfg_err", cfg_err, 0);
    idle(280);
    chk("R6 request count", nconv, 6);
    chk("R8 snapshot count", nsnap, 2);
    for (int k = 0; k < 6; k++) begin
      chk("R6 channel", cc[k], ech[k%3]);
      chk("R6 range", cr[k], erg[k%3]);
      chk("R6 diff flag", cd[k], edf[k%3]);
    end
    chk("R7 slot spacing a", ct[1] - ct[0], S);
    chk("R7 slot spacing across digital", ct[2] - ct[1], S);
    chk("R4 scan period", ct[3] - ct[0], 100);
    chk("R8 snapshot lead", ct[0] - stt[0], 2);
    chk("R8 snapshot period", stt[1] - stt[0], 100);
    chk("R9 no overrun", overrun, 0);
    en = 1'b0; idle(2);
  endtask

  task automatic t_clamp();
    wr(0, mk(0, 2, 3));
    list_len = 1; interval = 5;
    clr(); en = 1'b1;
    idle(1);
    chk("R5 clamped", clamped, 1);
    idle(110);
    chk("R4 clamped ticks seen", nconv >= 4, 1);
    for (int k = 0; k < 3; k++) chk("R4 clamped period", ct[k+1] - ct[k], S);
    chk("R8 no snapshot without digital", nsnap, 0);
    chk("R6 diff channel", cc[0], 2);
    en = 1'b0; interval = 100; idle(2);
    chk("R5 not clamped", clamped, 0);
  endtask

  task automatic t_overrun();
    int ech[3] = '{1, 4, 7};
    wr(0, mk(1, 1, 2)); wr(1, mk(1, 4, 2)); wr(2, mk(0, 7, 5));
    list_len = 3; interval = 30;
    clr(); en = 1'b1;
    idle(150);
    chk("R9 overrun set", overrun, 1);
    chk("R9 two scans done", nconv >= 6, 1);
    for (int k = 0; k < 5; k++) chk("R9 scan intact spacing", ct[k+1] - ct[k], S);
    for (int k = 0; k < 6; k++) chk("R9 scan order kept", cc[k], ech[k%3]);
    en = 1'b0; idle(2);
    chk("R13 armed low", armed, 0);
    chk("R13 busy low", busy, 0);
    chk("R13 flag held while idle", overrun, 1);
    list_len = 1; interval = 100;
    en = 1'b1; idle(1);
    chk("R13 flag cleared on start", overrun, 0);
    en = 1'b0; idle(2);
  endtask

  task automatic t_cfgerr();
    wr(0, mk(0, 1, 7)); wr(1, mk(1, 2, 2));
    list_len = 2; interval = 40;
    clr(); en = 1'b1;
    idle(150);
    chk("R3 cfg_err", cfg_err, 1);
    chk("R3 not armed", armed, 0);
    chk("R3 no requests", nconv, 0);
    chk("R3 no snapshot", nsnap, 0);
    en = 1'b0; idle(2);
    wr(1, mk(2, 3, 2)); wr(2, mk(1, 5, 7));
    list_len = 3;
    clr(); en = 1'b1;
    idle(70);
    chk("R3 digital range ignored", cfg_err, 0);
    chk("R3 armed with wide only", armed, 1);
    chk("R3 request issued", nconv >= 1, 1);
    chk("R3 wide range on request", cr[0], 7);
    en = 1'b0; idle(2);
  endtask

  task automatic t_ext();
    wr(0, mk(0, 6, 1));
    list_len = 1; ext_sel = 1; interval = 10;
    en = 1'b1; idle(10);
    clr();
    pulse(); idle(47);
    pulse(); idle(47);
    pulse(); idle(7);
    chk("R11 no flag yet", ext_fast, 0);
    pulse(); idle(47);
    pulse(); idle(30);
    chk("R11 ext_fast", ext_fast, 1);
    chk("R10 R11 request count", nconv, 4);
    chk("R10 edge spacing a", ct[1] - ct[0], 50);
    chk("R10 edge spacing b", ct[2] - ct[1], 50);
    chk("R11 early edge dropped", ct[3] - ct[2], 60);
    en = 1'b0; ext_sel = 0; idle(2);
  endtask

  task automatic t_len();
    for (int k = 0; k < 4; k++) wr(k, mk(1, k, k));
    list_len = 2; interval = 100;
    clr(); en = 1'b1;
    idle(130);
    chk("R12 only active entries", nconv, 2);
    chk("R12 last active channel", cc[1], 1);
    en = 1'b0; idle(2);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_mixed();
    t_clamp();
    t_overrun();
    t_cfgerr();
    t_ext();
    t_len();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule